// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block places a bank of 8-bit PHY delay registers behind a single 32-bit host-visible port word. Software never addresses the delay registers directly. It writes one port word that holds a PHY register index and a write byte. It then raises a request bit in that same word. The block watches the request bits for 0-to-1 transitions. On a write request it stores the byte into the selected delay register. On a read request it copies the selected register into a read-back byte of the port word.

A completion flag in the port word tells software that the access has been carried out. The flag stays set until software drops both request bits. Nine delay registers are provided by default, one for each bus timing mode. Their contents are driven out in parallel towards the delay lines. After reset, software is expected to load its own start-up delay values through the port.

Top module: `phy_access_port`

## Requirements
- R1: After reset, every bit of the port word reads 0 and every delay register holds 0.
- R2: Port word fields are as follows. Bits 7:0 are the PHY index and bits 15:8 are the write byte; both are written by software and read back unchanged. Bits 23:16 are the read byte and bit 26 is the completion flag; both are read-only. Bits 31:27 always read 0, and software writes to any read-only or unused bit have no effect.
- R3: Bit 24 is the write request. The clock edge after the one that captures a 0-to-1 change of bit 24 stores the write byte into the register selected by the index, and the new value appears on `delayOut`.
- R4: A write request stays in effect only at its rising transition. While bit 24 stays at 1, changing the index or write byte changes no delay register. The next write happens only after bit 24 returns to 0 and is set again.
- R5: Bit 25 is the read request. The clock edge after the one that captures a 0-to-1 change of bit 25 loads the selected register's value into bits 23:16.
- R6: The completion flag (bit 26) becomes 1 at the same edge that carries out a read or write. It stays 1 while either request bit is 1. It returns to 0 at the first edge at which both request bits are 0.
- R7: An index at or above the register count (9 by default, so 0x09 and up) is still acknowledged. A write to such an index changes no register, and a read from it returns 0.
- R8: A start-up sequence of writes that loads 4, 4, 9, 2 and 3 into indices 0x00, 0x01, 0x06, 0x07 and 0x08 leaves those values on `delayOut`. Every other register stays 0. Slot i of `delayOut` is bits 8i+7:8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe for the port word |
| regWrData | input | 32 | Host write value for the port word |
| regRdData | output | 32 | Current port word as seen by the host |
| delayOut | output | 72 | All delay registers side by side, slot i at bits 8i+7:8i |

## Verification
A wrong internal state shows up at the ports within one or two clocks. A stale request-history bit either repeats a write while a request is held, which `delayOut` exposes at the next edge, or drops a write that was asked for. A bad completion flag is visible in bit 26 of the port word at the edge after the access, or at the edge after both requests fall. A mis-selected register shows in either the read byte or the wrong `delayOut` slot right after the access. The bench samples each of these at the exact edge where the change is due.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = 8;
  localparam int BYTE_W    = 8;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;

  // strobes from control to datapath
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } portStrobes_t;
endpackage

// File: rtl/phy_port_ctrl.sv
module phy_port_ctrl
  import phy_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrReq,
  input  logic         rdReq,
  output portStrobes_t strb,
  output logic         ackFlag
);
  logic wrSeen, rdSeen;

  always_comb begin
    strb.wrFire = wrReq & ~wrSeen;
    strb.rdFire = rdReq & ~rdSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSeen  <= 1'b0;
      rdSeen  <= 1'b0;
      ackFlag <= 1'b0;
    end else begin
      wrSeen <= wrReq;
      rdSeen <= rdReq;
      if (strb.wrFire || strb.rdFire)
        ackFlag <= 1'b1;
      else if (!wrReq && !rdReq)
        ackFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_port_datapath.sv
module phy_port_datapath
  import phy_port_pkg::*;
#(
  parameter int NUM_REGS = 9,
  localparam int FLAT_W  = NUM_REGS * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  input  portStrobes_t      strb,
  input  logic              ackFlag,
  output logic              wrReq,
  output logic              rdReq,
  output logic [WORD_W-1:0] portWord,
  output logic [FLAT_W-1:0] delayFlat
);
  logic [IDX_W-1:0]  idxQ;
  logic [BYTE_W-1:0] wByteQ, rByteQ, selByte;
  logic [BYTE_W-1:0] bank [NUM_REGS];
  logic              inRange;

  assign inRange = (idxQ < IDX_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= '0;
      wByteQ <= '0;
      wrReq  <= 1'b0;
      rdReq  <= 1'b0;
    end else if (busWrEn) begin
      idxQ   <= busWrData[IDX_W-1:0];
      wByteQ <= busWrData[WDATA_LSB +: BYTE_W];
      wrReq  <= busWrData[WR_BIT];
      rdReq  <= busWrData[RD_BIT];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)
        bank[g] <= '0;
      else if (strb.wrFire && idxQ == IDX_W'(g))
        bank[g] <= wByteQ;
    end
    assign delayFlat[g*BYTE_W +: BYTE_W] = bank[g];
  end

  always_comb begin
    selByte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (inRange && idxQ == IDX_W'(i)) selByte = bank[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rByteQ <= '0;
    else if (strb.rdFire) rByteQ <= selByte;
  end

  always_comb begin
    portWord                          = '0;
    portWord[IDX_W-1:0]               = idxQ;
    portWord[WDATA_LSB +: BYTE_W]     = wByteQ;
    portWord[RDATA_LSB +: BYTE_W]     = rByteQ;
    portWord[WR_BIT]                  = wrReq;
    portWord[RD_BIT]                  = rdReq;
    portWord[ACK_BIT]                 = ackFlag;
  end
endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
  import phy_port_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [WORD_W-1:0]          regWrData,
  output logic [WORD_W-1:0]          regRdData,
  output logic [NUM_REGS*BYTE_W-1:0] delayOut
);
  portStrobes_t strb;
  logic wrReq, rdReq, ackFlag;

  phy_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .rdReq(rdReq),
    .strb(strb), .ackFlag(ackFlag)
  );

  phy_port_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(regWrEn), .busWrData(regWrData),
    .strb(strb), .ackFlag(ackFlag), .wrReq(wrReq), .rdReq(rdReq),
    .portWord(regRdData), .delayFlat(delayOut)
  );
endmodule

// File: rtl/phy_port_checker.sv
module phy_port_checker
  import phy_port_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       regWrEn,
  input logic [WORD_W-1:0]          regWrData,
  input logic [WORD_W-1:0]          regRdData,
  input logic [NUM_REGS*BYTE_W-1:0] delayOut
);
  p_fields_track_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[15:0] == $past(regWrData[15:0]) && regRdData[31:27] == 5'd0));

  p_write_on_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(delayOut) |-> ($past(regRdData[WR_BIT]) && !$past(regRdData[WR_BIT], 2)));

  p_read_on_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regRdData[23:16]) |-> $past(regRdData[RD_BIT]));

  p_ack_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[ACK_BIT]) |-> ($past(regRdData[WR_BIT]) || $past(regRdData[RD_BIT])));

  p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[WR_BIT] && !regRdData[RD_BIT]) |=> !regRdData[ACK_BIT]);
endmodule

bind phy_access_port phy_port_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .delayOut(delayOut)
);

// File: tb/tb_phy_access_port.sv
module tb_phy_access_port;
  localparam int NREG = 9;
  localparam int FW   = NREG * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [FW-1:0] delayOut;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  phy_access_port #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .delayOut(delayOut)
  );

  function automatic logic [FW-1:0] modelFlat();
    logic [FW-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [31:0] w);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = w;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic [7:0] idx, input logic [7:0] dat, input bit wr, input bit rd);
    return {6'd0, rd, wr, 8'd0, dat, idx};
  endfunction

  task automatic phyWrite(input logic [7:0] idx, input logic [7:0] dat);
    busWrite(word(idx, dat, 0, 0));
    busWrite(word(idx, dat, 1, 0));
    busWrite(word(idx, dat, 0, 0));
    if (idx < NREG) model[idx] = dat;
  endtask

  task automatic phyRead(input logic [7:0] idx, output logic [7:0] val, output bit ack);
    busWrite(word(idx, 8'h00, 0, 1));
    tick(1);
    val = regRdData[23:16];
    ack = regRdData[26];
    busWrite(word(idx, 8'h00, 0, 0));
  endtask

  task automatic testReset();
    check(regRdData == 32'd0, "R1 port word", regRdData, 0);
    check(delayOut == '0, "R1 delays", delayOut, 0);
  endtask

  task automatic testFields();
    busWrite(32'hFCFF_1234);
    check(regRdData == 32'h0000_1234, "R2 ro/unused bits ignored", regRdData, 32'h1234);
    check(delayOut == modelFlat(), "R2 no access", delayOut, modelFlat());
    busWrite(32'h0000_0000);
  endtask

  task automatic testWriteTiming();
    busWrite(word(8'h03, 8'h5A, 0, 0));
    busWrite(word(8'h03, 8'h5A, 1, 0));
    check(delayOut == modelFlat(), "R3 not yet written", delayOut, modelFlat());
    tick(1);
    model[3] = 8'h5A;
    check(delayOut == modelFlat(), "R3 written", delayOut, modelFlat());
    check(regRdData[26] == 1'b1, "R6 ack with write", regRdData[26], 1);
    tick(3);
    check(regRdData[26] == 1'b1, "R6 ack held", regRdData[26], 1);
    busWrite(word(8'h03, 8'h5A, 0, 0));
    check(regRdData[26] == 1'b1, "R6 ack before clear edge", regRdData[26], 1);
    tick(1);
    check(regRdData[26] == 1'b0, "R6 ack cleared", regRdData[26], 0);
  endtask

  task automatic testOnce();
    busWrite(word(8'h04, 8'h11, 1, 0));
    tick(1);
    model[4] = 8'h11;
    busWrite(word(8'h04, 8'h22, 1, 0));
    busWrite(word(8'h05, 8'h33, 1, 0));
    tick(3);
    check(delayOut == modelFlat(), "R4 held request no rewrite", delayOut, modelFlat());
    busWrite(word(8'h05, 8'h33, 0, 0));
    busWrite(word(8'h05, 8'h33, 1, 0));
    tick(1);
    model[5] = 8'h33;
    check(delayOut == modelFlat(), "R4 new edge writes", delayOut, modelFlat());
    busWrite(word(8'h05, 8'h33, 0, 0));
  endtask

  task automatic testInit();
    phyWrite(8'h00, 8'd4);
    phyWrite(8'h01, 8'd4);
    phyWrite(8'h06, 8'd9);
    phyWrite(8'h07, 8'd2);
    phyWrite(8'h08, 8'd3);
    check(delayOut == modelFlat(), "R8 start-up values", delayOut, modelFlat());
  endtask

  task automatic testRead();
    logic [7:0] v; bit a;
    phyRead(8'h06, v, a);
    check(v == 8'd9, "R5 read idx 6", v, 9);
    check(a == 1'b1, "R6 ack with read", a, 1);
    phyRead(8'h00, v, a);
    check(v == 8'd4, "R5 read idx 0", v, 4);
    phyRead(8'h08, v, a);
    check(v == 8'd3, "R5 read idx 8", v, 3);
  endtask

  task automatic testRange();
    logic [7:0] v; bit a;
    busWrite(word(8'h20, 8'h77, 0, 0));
    busWrite(word(8'h20, 8'h77, 1, 0));
    tick(1);
    check(delayOut == modelFlat(), "R7 write discarded", delayOut, modelFlat());
    check(regRdData[26] == 1'b1, "R7 write acked", regRdData[26], 1);
    busWrite(word(8'h20, 8'h77, 0, 0));
    phyRead(8'h07, v, a);
    check(v == 8'd2, "R5 read idx 7", v, 2);
    phyRead(8'h09, v, a);
    check(v == 8'd0, "R7 read returns zero", v, 0);
    check(a == 1'b1, "R7 read acked", a, 1);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(3);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testWriteTiming();
    testOnce();
    testInit();
    testRead();
    testRange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule